// File: doc/BRIEF.md
# Multi-Channel DMA Register and Interrupt Unit

This block is the register file that sits between a 32-bit memory-mapped bus and a set of DMA channel engines. Software configures each channel through its own group of registers: source and destination address modes, the two addresses, and a byte count. A single global command word launches or cancels any set of channels at once. The block turns that word into one-cycle start or abort pulses towards the engines. The configuration is driven straight out to them.

Each engine reports completion and abort events back to the block. The block latches them into a per-channel request register, masks them with an enable register, and raises an interrupt line. Channels 0 and 1 share the first interrupt line. Every later channel has a line of its own. While a channel is running, a read of its size register returns the live outstanding byte count that the engine reports.

Top module: `dmac_reg_unit`

## Requirements
- R1: After reset every configuration, request and enable register reads zero, and the start, abort and interrupt outputs are low.
- R2: A write to byte offset 0x000 with bit 31 clear raises `eng_start[n]` for exactly one cycle, in the cycle after the write, for every channel n whose bit n is set in the written word. No abort is raised.
- R3: A write to offset 0x000 with bit 31 set raises `eng_abort[n]` for one cycle for each selected channel instead, and no start. Start and abort are never high together for a channel.
- R4: Channel n's group starts at 0x100 + 0x40*n. Its registers are:
  - 0x20: source mode, 2-bit field at bits 5:4.
  - 0x24: destination mode, 2-bit field at bits 5:4.
  - 0x28: source address.
  - 0x2C: destination address.
  - 0x30: size.

  Each reads back what was written, with unimplemented mode bits reading zero. Each is driven on the matching `cfg_*` output slice.
- R5: A channel is running from its start pulse until its next done or abort event. While it runs, a read of offset 0x30 returns `eng_remain` for that channel. Otherwise the read returns the programmed size.
- R6: A done event sets bit 1 of the request register at offset 0x14. An abort event sets both bit 1 and bit 13.
- R7: Writing a one to a request bit clears that bit, and writing a zero leaves it unchanged. If an event and a clearing write hit the same bit in one cycle, the bit stays set.
- R8: Offset 0x18 is the enable mask, holding bits 1 and 13. Offset 0x1C reads request AND enable, and is zero when nothing enabled is pending. Offset 0x10 shows the live status inputs: `eng_stat[2n]` appears on bit 1 and `eng_stat[2n+1]` on bit 13.
- R9: A channel interrupts when any of its detect bits is set. Channels 0 and 1 drive `irq[0]`, and channel n≥2 drives `irq[n-1]`. The line follows the detect word with no extra cycle.
- R10: The following read zero, and writes to them change no register:
  - the global area except offset 0x000;
  - unlisted offsets inside a channel group;
  - groups of channels at or above N_CH.

  The command register reads zero.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_start | output | N_CH | One-cycle start pulse per channel |
| eng_abort | output | N_CH | One-cycle abort pulse per channel |
| eng_done_evt | input | N_CH | Done event pulse per channel |
| eng_abort_evt | input | N_CH | Abort event pulse per channel |
| eng_stat | input | 2*N_CH | Live status per channel: {abort, done} |
| eng_remain | input | 32*N_CH | Outstanding bytes per channel |
| cfg_src_mode | output | 2*N_CH | Source mode per channel |
| cfg_dst_mode | output | 2*N_CH | Destination mode per channel |
| cfg_src_addr | output | 32*N_CH | Source address per channel |
| cfg_dst_addr | output | 32*N_CH | Destination address per channel |
| cfg_size | output | 32*N_CH | Programmed size per channel |
| irq | output | N_CH-1 | Interrupt lines; line 0 shared by channels 0 and 1 |

## Verification
Command words are tried with several channel masks and with bit 31 both clear and set. This separates start from abort decoding and catches a mask applied to the wrong channels. Done events, abort events and status levels are fed to different channels under full, partial and empty enable masks. These patterns tell the latched request apart from the live status and from the masked detect word. Shared-line tests raise events on channel 0 and channel 1 in turn, and check that the other channel's detect word stays zero. A simultaneous event and clearing write shows the set-priority rule. Writes to the gaps, to the global area and to a channel group beyond the last channel show whether decoding aliases onto real registers.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;

    localparam int unsigned DW       = 32;
    localparam int unsigned BIT_DONE = 1;
    localparam int unsigned BIT_ABT  = 13;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_REQ,
        SEL_EN,
        SEL_DET,
        SEL_SMODE,
        SEL_DMODE,
        SEL_SADDR,
        SEL_DADDR,
        SEL_SIZE
    } chan_sel_e;

    // event vector ordering: [0] = done, [1] = abort
    typedef struct packed {
        logic [1:0]    smode;
        logic [1:0]    dmode;
        logic [DW-1:0] saddr;
        logic [DW-1:0] daddr;
        logic [DW-1:0] size;
        logic [1:0]    req;
        logic [1:0]    en;
        logic          running;
    } chan_regs_t;

    function automatic chan_sel_e decode_ofs(input logic [5:0] ofs);
        case (ofs)
            6'h10:   return SEL_STAT;
            6'h14:   return SEL_REQ;
            6'h18:   return SEL_EN;
            6'h1C:   return SEL_DET;
            6'h20:   return SEL_SMODE;
            6'h24:   return SEL_DMODE;
            6'h28:   return SEL_SADDR;
            6'h2C:   return SEL_DADDR;
            6'h30:   return SEL_SIZE;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] place_evt(input logic [1:0] v);
        logic [DW-1:0] w;
        w           = '0;
        w[BIT_DONE] = v[0];
        w[BIT_ABT]  = v[1];
        return w;
    endfunction

    function automatic logic [1:0] pick_evt(input logic [DW-1:0] w);
        return {w[BIT_ABT], w[BIT_DONE]};
    endfunction

endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
    import dmac_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_CH   = 8,
    localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int unsigned GRP_W = ADDR_W - 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_cmd,
    output logic              ch_hit,
    output logic [CH_W-1:0]   ch_idx,
    output chan_sel_e         sel
);

    localparam logic [ADDR_W-1:0] CH_AREA = ADDR_W'('h100);

    logic [ADDR_W-1:0] rel;
    logic [GRP_W-1:0]  grp;
    logic              in_area;

    always_comb begin
        rel     = addr - CH_AREA;
        grp     = rel[ADDR_W-1:6];
        in_area = (addr >= CH_AREA);
        is_cmd  = (addr == '0);
        ch_hit  = in_area && (grp < GRP_W'(N_CH));
        ch_idx  = grp[CH_W-1:0];
        sel     = decode_ofs(rel[5:0]);
    end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_reg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  chan_sel_e     sel,
    input  logic [DW-1:0] wdata,
    input  logic          start_i,
    input  logic          done_evt_i,
    input  logic          abort_evt_i,
    input  logic [1:0]    stat_i,
    input  logic [DW-1:0] remain_i,
    output logic [DW-1:0] rd_word_o,
    output logic [1:0]    smode_o,
    output logic [1:0]    dmode_o,
    output logic [DW-1:0] saddr_o,
    output logic [DW-1:0] daddr_o,
    output logic [DW-1:0] size_o,
    output logic          irq_o
);

    chan_regs_t q, d;
    logic [1:0] det;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (sel)
                SEL_REQ:   d.req   = q.req & ~pick_evt(wdata);
                SEL_EN:    d.en    = pick_evt(wdata);
                SEL_SMODE: d.smode = wdata[5:4];
                SEL_DMODE: d.dmode = wdata[5:4];
                SEL_SADDR: d.saddr = wdata;
                SEL_DADDR: d.daddr = wdata;
                SEL_SIZE:  d.size  = wdata;
                default:   d = d;
            endcase
        end
        // events take priority over a clearing write
        if (done_evt_i)  d.req[0] = 1'b1;
        if (abort_evt_i) d.req    = 2'b11;

        if (start_i)                       d.running = 1'b1;
        else if (done_evt_i || abort_evt_i) d.running = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        det = q.req & q.en;
        case (sel)
            SEL_STAT:  rd_word_o = place_evt(stat_i);
            SEL_REQ:   rd_word_o = place_evt(q.req);
            SEL_EN:    rd_word_o = place_evt(q.en);
            SEL_DET:   rd_word_o = place_evt(det);
            SEL_SMODE: rd_word_o = {26'd0, q.smode, 4'd0};
            SEL_DMODE: rd_word_o = {26'd0, q.dmode, 4'd0};
            SEL_SADDR: rd_word_o = q.saddr;
            SEL_DADDR: rd_word_o = q.daddr;
            SEL_SIZE:  rd_word_o = q.running ? remain_i : q.size;
            default:   rd_word_o = '0;
        endcase
    end

    assign smode_o = q.smode;
    assign dmode_o = q.dmode;
    assign saddr_o = q.saddr;
    assign daddr_o = q.daddr;
    assign size_o  = q.size;
    assign irq_o   = |det;

endmodule

// File: rtl/dmac_reg_unit.sv
module dmac_reg_unit
    import dmac_reg_pkg::*;
#(
    parameter int unsigned N_CH   = 8,   // 2..31
    parameter int unsigned ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [N_CH-1:0]      eng_start,
    output logic [N_CH-1:0]      eng_abort,
    input  logic [N_CH-1:0]      eng_done_evt,
    input  logic [N_CH-1:0]      eng_abort_evt,
    input  logic [2*N_CH-1:0]    eng_stat,
    input  logic [32*N_CH-1:0]   eng_remain,
    output logic [2*N_CH-1:0]    cfg_src_mode,
    output logic [2*N_CH-1:0]    cfg_dst_mode,
    output logic [32*N_CH-1:0]   cfg_src_addr,
    output logic [32*N_CH-1:0]   cfg_dst_addr,
    output logic [32*N_CH-1:0]   cfg_size,
    output logic [N_CH-2:0]      irq
);

    localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int unsigned N_IRQ = N_CH - 1;

    typedef struct packed {
        logic [N_CH-1:0] start;
        logic [N_CH-1:0] abort;
        logic [DW-1:0]   rdata;
    } top_state_t;

    top_state_t q, d;

    logic            dec_cmd;
    logic            dec_hit;
    logic [CH_W-1:0] dec_idx;
    chan_sel_e       dec_sel;
    logic [DW-1:0]   rd_word [N_CH];
    logic [N_CH-1:0] ch_irq;

    dmac_addr_dec #(.ADDR_W(ADDR_W), .N_CH(N_CH)) dec_i (
        .addr   (bus_addr),
        .is_cmd (dec_cmd),
        .ch_hit (dec_hit),
        .ch_idx (dec_idx),
        .sel    (dec_sel)
    );

    always_comb begin
        d       = q;
        d.start = '0;
        d.abort = '0;
        if (bus_wr && dec_cmd) begin
            for (int i = 0; i < N_CH; i++) begin
                if (bus_wdata[i]) begin
                    if (bus_wdata[31]) d.abort[i] = 1'b1;
                    else               d.start[i] = 1'b1;
                end
            end
        end
        if (bus_rd) d.rdata = dec_hit ? rd_word[dec_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        dmac_chan_regs ch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bus_wr && dec_hit && (dec_idx == CH_W'(n))),
            .sel         (dec_sel),
            .wdata       (bus_wdata),
            .start_i     (d.start[n]),
            .done_evt_i  (eng_done_evt[n]),
            .abort_evt_i (eng_abort_evt[n]),
            .stat_i      (eng_stat[2*n +: 2]),
            .remain_i    (eng_remain[32*n +: 32]),
            .rd_word_o   (rd_word[n]),
            .smode_o     (cfg_src_mode[2*n +: 2]),
            .dmode_o     (cfg_dst_mode[2*n +: 2]),
            .saddr_o     (cfg_src_addr[32*n +: 32]),
            .daddr_o     (cfg_dst_addr[32*n +: 32]),
            .size_o      (cfg_size[32*n +: 32]),
            .irq_o       (ch_irq[n])
        );
    end

    for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
        if (k == 0) begin : g_shared
            assign irq[k] = ch_irq[0] | ch_irq[1];
        end else begin : g_own
            assign irq[k] = ch_irq[k+1];
        end
    end

    assign bus_rdata = q.rdata;
    assign eng_start = q.start;
    assign eng_abort = q.abort;

endmodule

// File: rtl/dmac_reg_unit_chk.sv
module dmac_reg_unit_chk #(
    parameter int unsigned N_CH   = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [N_CH-1:0]    eng_start,
    input logic [N_CH-1:0]    eng_abort,
    input logic [N_CH-1:0]    eng_done_evt,
    input logic [N_CH-1:0]    eng_abort_evt,
    input logic [N_CH-2:0]    irq
);

    logic [N_CH-1:0] evt_any;
    assign evt_any = eng_done_evt | eng_abort_evt;

    // R2
    start_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_start) |-> ($past(bus_wr) && $past(bus_addr) == '0 && !$past(bus_wdata[31])));

    // R3
    abort_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_abort) |-> ($past(bus_wr) && $past(bus_addr) == '0 && $past(bus_wdata[31])));

    // R3
    start_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start & eng_abort) == '0);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_rd) |-> $stable(bus_rdata));

    // R10
    global_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == ADDR_W'('h4)) |-> (bus_rdata == '0));

    // R9
    shared_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> ($past(evt_any[0] | evt_any[1]) || $past(bus_wr)));

    for (genvar k = 1; k < N_CH - 1; k++) begin : g_own_irq
        // R9
        own_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[k]) |-> ($past(evt_any[k+1]) || $past(bus_wr)));
    end

endmodule

bind dmac_reg_unit dmac_reg_unit_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .eng_start     (eng_start),
    .eng_abort     (eng_abort),
    .eng_done_evt  (eng_done_evt),
    .eng_abort_evt (eng_abort_evt),
    .irq           (irq)
);

// File: tb/dmac_reg_unit_tb_top.sv
`timescale 1ns/1ps
module dmac_reg_unit_tb_top;

    localparam int N  = 8;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N-1:0]      eng_start, eng_abort;
    logic [N-1:0]      eng_done_evt = '0;
    logic [N-1:0]      eng_abort_evt = '0;
    logic [2*N-1:0]    eng_stat = '0;
    logic [32*N-1:0]   eng_remain = '0;
    logic [2*N-1:0]    cfg_src_mode, cfg_dst_mode;
    logic [32*N-1:0]   cfg_src_addr, cfg_dst_addr, cfg_size;
    logic [N-2:0]      irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dmac_reg_unit #(.N_CH(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_done_evt(eng_done_evt), .eng_abort_evt(eng_abort_evt),
        .eng_stat(eng_stat), .eng_remain(eng_remain),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_size(cfg_size), .irq(irq)
    );

    function automatic logic [AW-1:0] ra(input int ch, input int ofs);
        return AW'(32'h100 + 32'h40 * ch + ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse_evt(input int ch, input logic is_abort);
        @(negedge clk);
        if (is_abort) eng_abort_evt[ch] = 1'b1;
        else          eng_done_evt[ch]  = 1'b1;
        @(negedge clk);
        eng_abort_evt = '0;
        eng_done_evt  = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 start", 32'(eng_start), 0);
        check("R1 abort", 32'(eng_abort), 0);
        check("R1 irq", 32'(irq), 0);
        bus_read(ra(0, 'h28), v); check("R1 saddr", v, 0);
        bus_read(ra(3, 'h14), v); check("R1 req", v, 0);
        bus_read(ra(7, 'h18), v); check("R1 en", v, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        bus_write(ra(2, 'h20), 32'h0000_0010);
        bus_write(ra(2, 'h24), 32'hFFFF_FFFF);
        bus_write(ra(2, 'h28), 32'h1234_5678);
        bus_write(ra(2, 'h2C), 32'h9ABC_DEF0);
        bus_write(ra(2, 'h30), 32'h0000_0400);
        bus_read(ra(2, 'h20), v); check("R4 smode rd", v, 32'h10);
        bus_read(ra(2, 'h24), v); check("R4 dmode rd", v, 32'h30);
        bus_read(ra(2, 'h28), v); check("R4 saddr rd", v, 32'h1234_5678);
        bus_read(ra(2, 'h2C), v); check("R4 daddr rd", v, 32'h9ABC_DEF0);
        bus_read(ra(2, 'h30), v); check("R4 size rd", v, 32'h400);
        check("R4 smode out", 32'(cfg_src_mode[5:4]), 1);
        check("R4 dmode out", 32'(cfg_dst_mode[5:4]), 3);
        check("R4 saddr out", cfg_src_addr[95:64], 32'h1234_5678);
        check("R4 daddr out", cfg_dst_addr[95:64], 32'h9ABC_DEF0);
        check("R4 size out", cfg_size[95:64], 32'h400);
        check("R4 other ch", cfg_src_addr[63:32], 0);
    endtask

    task automatic t_start();
        bus_write(AW'(0), 32'h0000_0005);
        check("R2 start pulse", 32'(eng_start), 32'h05);
        check("R2 no abort", 32'(eng_abort), 0);
        @(negedge clk);
        check("R2 one cycle", 32'(eng_start), 0);
    endtask

    task automatic t_abort();
        bus_write(AW'(0), 32'h8000_0012);
        check("R3 abort pulse", 32'(eng_abort), 32'h12);
        check("R3 no start", 32'(eng_start), 0);
        @(negedge clk);
        check("R3 one cycle", 32'(eng_abort), 0);
    endtask

    task automatic t_remain();
        logic [31:0] v;
        bus_write(ra(3, 'h30), 32'd100);
        eng_remain[32*3 +: 32] = 32'd40;
        bus_read(ra(3, 'h30), v); check("R5 idle size", v, 32'd100);
        bus_write(AW'(0), 32'h0000_0008);
        bus_read(ra(3, 'h30), v); check("R5 running remain", v, 32'd40);
        pulse_evt(3, 1'b0);
        bus_read(ra(3, 'h30), v); check("R5 after done", v, 32'd100);
        bus_write(ra(3, 'h14), 32'h0000_2002);
    endtask

    task automatic t_events();
        logic [31:0] v;
        bus_write(ra(4, 'h18), 32'hFFFF_FFFF);
        bus_read(ra(4, 'h18), v); check("R8 en bits", v, 32'h2002);
        pulse_evt(4, 1'b0);
        check("R9 irq ch4", 32'(irq), 32'h08);
        bus_read(ra(4, 'h14), v); check("R6 done req", v, 32'h2);
        bus_read(ra(4, 'h1C), v); check("R8 det", v, 32'h2);
        bus_write(ra(4, 'h14), 32'h2);
        check("R7 clear irq", 32'(irq), 0);
        bus_read(ra(4, 'h1C), v); check("R8 det cleared", v, 0);
        pulse_evt(4, 1'b1);
        bus_read(ra(4, 'h14), v); check("R6 abort sets both", v, 32'h2002);
        bus_write(ra(4, 'h14), 32'h2000);
        bus_read(ra(4, 'h14), v); check("R7 zero keeps bit", v, 32'h2);
        bus_write(ra(4, 'h14), 32'h2);
        bus_read(ra(4, 'h14), v); check("R7 cleared", v, 0);
        bus_write(ra(5, 'h18), 32'h2000);
        pulse_evt(5, 1'b0);
        bus_read(ra(5, 'h1C), v); check("R8 masked det", v, 0);
        check("R9 masked irq", 32'(irq), 0);
        eng_stat[2*6 +: 2] = 2'b10;
        bus_read(ra(6, 'h10), v); check("R8 status abort", v, 32'h2000);
        eng_stat[2*6 +: 2] = 2'b01;
        bus_read(ra(6, 'h10), v); check("R8 status done", v, 32'h2);
        eng_stat = '0;
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        eng_done_evt[5] = 1'b1;
        bus_wr = 1'b1; bus_addr = ra(5, 'h14); bus_wdata = 32'h2;
        @(negedge clk);
        eng_done_evt = '0; bus_wr = 1'b0;
        bus_read(ra(5, 'h14), v); check("R7 set wins", v, 32'h2);
        bus_write(ra(5, 'h14), 32'h2);
        bus_read(ra(5, 'h14), v); check("R7 clear after", v, 0);
    endtask

    task automatic t_shared();
        logic [31:0] v;
        bus_write(ra(0, 'h18), 32'h2);
        bus_write(ra(1, 'h18), 32'h2);
        pulse_evt(1, 1'b0);
        check("R9 shared by ch1", 32'(irq), 32'h01);
        bus_read(ra(0, 'h1C), v); check("R8 ch0 det zero", v, 0);
        bus_read(ra(1, 'h1C), v); check("R8 ch1 det", v, 32'h2);
        bus_write(ra(1, 'h14), 32'h2);
        check("R9 shared cleared", 32'(irq), 0);
        pulse_evt(0, 1'b0);
        check("R9 shared by ch0", 32'(irq), 32'h01);
        bus_write(ra(0, 'h14), 32'h2);
        check("R9 shared cleared 2", 32'(irq), 0);
        bus_write(ra(7, 'h18), 32'h2000);
        pulse_evt(7, 1'b1);
        check("R9 last line", 32'(irq), 32'h40);
        bus_write(ra(7, 'h14), 32'h2002);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_read(AW'(0), v); check("R10 cmd reads zero", v, 0);
        bus_read(AW'('h4), v); check("R10 global gap", v, 0);
        bus_write(ra(0, 'h00), 32'hFFFF_FFFF);
        bus_read(ra(0, 'h00), v); check("R10 group gap", v, 0);
        bus_write(ra(0, 'h34), 32'hFFFF_FFFF);
        bus_read(ra(0, 'h34), v); check("R10 group tail", v, 0);
        bus_write(ra(8, 'h20), 32'h30);
        bus_write(ra(8, 'h28), 32'hDEAD_BEEF);
        bus_read(ra(8, 'h28), v); check("R10 missing channel", v, 0);
        check("R10 no alias mode", 32'(cfg_src_mode[1:0]), 0);
        check("R10 no alias addr", cfg_src_addr[31:0], 0);
        check("R10 ch2 intact", cfg_src_addr[95:64], 32'h1234_5678);
        @(negedge clk); bus_rd = 1'b1; bus_addr = ra(2, 'h28);
        @(negedge clk); bus_rd = 1'b0; bus_addr = '0;
        @(negedge clk);
        check("R11 rdata holds", bus_rdata, 32'h1234_5678);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_start();
        t_abort();
        t_remain();
        t_events();
        t_set_wins();
        t_shared();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule